// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave with Deferred Nonvolatile Commit

This block is a slave on a two-wire serial bus (I2C-style). It serves a handful of configuration registers and keeps a nonvolatile shadow of them. The bus master writes a register pointer, then either writes data bytes or issues a repeated START and reads bytes back. Two registers are two bytes wide, and the pointer steps forward after every data byte. The working copy drives the block's configuration outputs continuously.

Each register write can also be saved to the nonvolatile copy, and a write-control bit in the address register decides when. When the bit is clear, everything written in a transfer is saved when the STOP arrives. When the bit is set, writes change only the working copy until the master sends a pointer-only write to the commit location. Writes to the address register are always saved. While a save is in progress, or while the working copy is being reloaded after reset, the slave refuses its address. The nonvolatile store is a small register array with a programmable hold time.

Top module: `twi_cfg_regs`

## Requirements
- R1: The slave ACKs only an address byte whose upper seven bits equal binary 1011 followed by the three device bits held in address register bits [2:0]. Any other address is NACKed and SDA is left released.
- R2: Byte locations are as follows. 02h/03h hold the high/low bytes of the control word. 08h/09h hold the high/low bytes of the frequency word, whose 10-bit code sits in bits [15:6]. 0Eh holds the 5-bit range offset. 0Dh holds the address register (bit 3 is write-control, bits [2:0] are the device bits). 37h returns the read-only 5-bit factory range. Unmapped locations read 00h.
- R3: The first data byte after a write address sets the pointer. Each further byte written or read advances the pointer by one.
- R4: A read is a pointer write, a repeated START, then the address with R/W=1. The slave sends bytes MSB first while the master ACKs, and releases SDA after the master's NACK.
- R5: With write-control = 0 (the reset default), data written in a transfer is saved to the nonvolatile copy at STOP and survives a reset.
- R6: With write-control = 1, a write changes only the working copy and does not start a save. A reset restores the previously saved value.
- R7: A write that carries only pointer 3Fh saves every register to the nonvolatile copy at STOP.
- R8: A write to the address register is saved at STOP whatever the write-control setting.
- R9: After a STOP that starts a save, busy is high for at least NV_BUSY_CYCLES clocks and every address byte is NACKed. Normal ACKs resume once busy falls.
- R10: Reset releases SDA and raises busy while the working registers are reloaded from the nonvolatile copy.
- R11: A write to 37h is ACKed and leaves every register unchanged.
- R12: Unused bits read back as fixed values: bits [5:0] of the control and frequency words read 0, 0Eh bits [7:5] read 0, and 0Dh bits [7:4] read 1.
- R13: The slave changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a reload from the nonvolatile copy |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| ctrl_word_o | output | 16 | Working control word |
| freq_code_o | output | 10 | Working 10-bit frequency code |
| range_off_o | output | 5 | Working range offset |
| addr_bits_o | output | 3 | Working device address bits |
| wr_ctl_o | output | 1 | Working write-control bit |
| nv_busy_o | output | 1 | Nonvolatile reload or save in progress |

## Verification
If the dirty or commit state is wrong, the fault does not appear until a later reset, when a register comes back with a stale or unexpected value. So the bench pairs every commit scenario with a reset followed by a readback. A wrong pointer shows up on the next byte read as data from the neighbouring location. A wrong busy sequencer shows up within one address byte as a missing or extra ACK. A mistimed pull-down shows up on the same SCL phase as an SDA edge while SCL is high, which the bus reads as a false START or STOP.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;
  localparam int NREG  = 4;
  localparam int IDX_W = $clog2(NREG);

  localparam logic [3:0] DEV_ID = 4'b1011;

  localparam logic [7:0] A_CTRL_HI = 8'h02;
  localparam logic [7:0] A_CTRL_LO = 8'h03;
  localparam logic [7:0] A_FREQ_HI = 8'h08;
  localparam logic [7:0] A_FREQ_LO = 8'h09;
  localparam logic [7:0] A_ADDR    = 8'h0D;
  localparam logic [7:0] A_RANGE   = 8'h0E;
  localparam logic [7:0] A_FACT    = 8'h37;
  localparam logic [7:0] A_COMMIT  = 8'h3F;

  localparam int I_CTRL  = 0;
  localparam int I_FREQ  = 1;
  localparam int I_RANGE = 2;
  localparam int I_ADDR  = 3;

  localparam logic [15:0] KEEP_CTRL  = 16'hFFC0;
  localparam logic [15:0] KEEP_FREQ  = 16'hFFC0;
  localparam logic [15:0] KEEP_RANGE = 16'h001F;
  localparam logic [15:0] KEEP_ADDR  = 16'h000F;
  localparam logic [7:0]  ADDR_FILL  = 8'hF0;
  localparam int          WC_BIT     = 3;

  typedef enum logic [2:0] {
    E_IDLE, E_ADDR, E_AACK, E_WDAT, E_WACK, E_RDAT, E_RACK
  } eng_st_t;

  typedef enum logic [1:0] {
    S_LOAD, S_IDLE, S_STORE, S_HOLD
  } seq_st_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;

  assign scl_now = scl_sh[SYNC_STAGES-1];
  assign sda_now = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end
  end

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign sda_lvl   = sda_now;
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_lvl,
  input  logic [2:0] dev_addr,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       wr_v,
  output logic       wr_first,
  output logic [7:0] wr_byte,
  output logic       rd_req
);
  eng_st_t    st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw, first, mack;

  always_ff @(posedge clk) begin
    wr_v   <= 1'b0;
    rd_req <= 1'b0;
    if (rst) begin
      st       <= E_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
      wr_first <= 1'b0;
      wr_byte  <= '0;
    end else if (start_det) begin
      st       <= E_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= E_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        E_ADDR, E_WDAT: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_lvl};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == E_ADDR) begin
              if (shreg[7:1] == {DEV_ID, dev_addr} && !busy) begin
                sda_pull <= 1'b1;
                rw       <= shreg[0];
                first    <= 1'b1;
                st       <= E_AACK;
              end else begin
                st <= E_IDLE;
              end
            end else begin
              wr_v     <= 1'b1;
              wr_first <= first;
              wr_byte  <= shreg;
              first    <= 1'b0;
              sda_pull <= 1'b1;
              st       <= E_WACK;
            end
          end
        end
        E_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg    <= rd_data;
              sda_pull <= ~rd_data[7];
              rd_req   <= 1'b1;
              st       <= E_RDAT;
            end else begin
              sda_pull <= 1'b0;
              st       <= E_WDAT;
            end
          end
        end
        E_WACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= E_WDAT;
          end
        end
        E_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              cnt      <= '0;
              sda_pull <= 1'b0;
              st       <= E_RACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_pull <= ~shreg[6];
            end
          end
        end
        E_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              shreg    <= rd_data;
              sda_pull <= ~rd_data[7];
              rd_req   <= 1'b1;
              st       <= E_RDAT;
            end else begin
              st <= E_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_cfg_pkg::*;
#(
  parameter int          NV_BUSY_CYCLES = 2000,
  parameter logic [15:0] DEF_CTRL       = 16'h0100,
  parameter logic [9:0]  DEF_FREQ       = 10'd500,
  parameter logic [4:0]  FACTORY_RANGE  = 5'h12,
  parameter logic [2:0]  DEF_DEV        = 3'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stop_det,
  input  logic        wr_v,
  input  logic        wr_first,
  input  logic [7:0]  wr_byte,
  input  logic        rd_req,
  output logic [7:0]  rd_data,
  output logic [15:0] ctrl_word,
  output logic [9:0]  freq_code,
  output logic [4:0]  range_off,
  output logic [2:0]  dev_addr,
  output logic        wr_ctl,
  output logic        busy
);
  localparam int TMR_W = $clog2(NV_BUSY_CYCLES + 1);
  localparam logic [NREG-1:0]  ADDR_ONLY = NREG'(1 << I_ADDR);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NREG - 1);

  function automatic logic [15:0] init_word(input int i);
    case (i)
      I_CTRL:  return DEF_CTRL & KEEP_CTRL;
      I_FREQ:  return {DEF_FREQ, 6'b0};
      I_RANGE: return {11'b0, FACTORY_RANGE};
      default: return {13'b0, DEF_DEV};
    endcase
  endfunction

  logic [15:0]      nv_mem [NREG];
  logic [15:0]      wreg   [NREG];
  seq_st_t          seq;
  logic [IDX_W-1:0] idx;
  logic [NREG-1:0]  dirty, set_q, sel_now;
  logic             commit_all;
  logic [7:0]       ptr;
  logic [TMR_W-1:0] tmr;

  initial begin
    for (int i = 0; i < NREG; i++) nv_mem[i] = init_word(i);
  end

  always_ff @(posedge clk) begin
    if (seq == S_STORE && set_q[idx]) nv_mem[idx] <= wreg[idx];
  end

  always_comb begin
    if (commit_all)              sel_now = '1;
    else if (wreg[I_ADDR][WC_BIT]) sel_now = dirty & ADDR_ONLY;
    else                         sel_now = dirty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq        <= S_LOAD;
      idx        <= '0;
      ptr        <= '0;
      dirty      <= '0;
      set_q      <= '0;
      commit_all <= 1'b0;
      tmr        <= '0;
      for (int i = 0; i < NREG; i++) wreg[i] <= '0;
    end else begin
      case (seq)
        S_LOAD: begin
          wreg[idx] <= nv_mem[idx];
          idx       <= idx + 1'b1;
          if (idx == LAST_IDX) seq <= S_IDLE;
        end
        S_STORE: begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            seq <= S_HOLD;
            tmr <= '0;
          end
        end
        S_HOLD: begin
          tmr <= tmr + 1'b1;
          if (tmr == TMR_W'(NV_BUSY_CYCLES - 1)) seq <= S_IDLE;
        end
        default: begin
          if (stop_det && sel_now != '0) begin
            set_q <= sel_now;
            idx   <= '0;
            seq   <= S_STORE;
          end
        end
      endcase

      if (wr_v && seq == S_IDLE) begin
        if (wr_first) begin
          ptr <= wr_byte;
          if (wr_byte == A_COMMIT) commit_all <= 1'b1;
        end else begin
          ptr <= ptr + 8'd1;
          case (ptr)
            A_CTRL_HI: begin wreg[I_CTRL][15:8] <= wr_byte & KEEP_CTRL[15:8]; dirty[I_CTRL] <= 1'b1; end
            A_CTRL_LO: begin wreg[I_CTRL][7:0]  <= wr_byte & KEEP_CTRL[7:0];  dirty[I_CTRL] <= 1'b1; end
            A_FREQ_HI: begin wreg[I_FREQ][15:8] <= wr_byte & KEEP_FREQ[15:8]; dirty[I_FREQ] <= 1'b1; end
            A_FREQ_LO: begin wreg[I_FREQ][7:0]  <= wr_byte & KEEP_FREQ[7:0];  dirty[I_FREQ] <= 1'b1; end
            A_RANGE:   begin wreg[I_RANGE] <= {8'h00, wr_byte & KEEP_RANGE[7:0]}; dirty[I_RANGE] <= 1'b1; end
            A_ADDR:    begin wreg[I_ADDR]  <= {8'h00, wr_byte & KEEP_ADDR[7:0]};  dirty[I_ADDR]  <= 1'b1; end
            default: ;
          endcase
        end
      end else if (rd_req) begin
        ptr <= ptr + 8'd1;
      end

      if (stop_det) begin
        dirty      <= '0;
        commit_all <= 1'b0;
      end
    end
  end

  always_comb begin
    case (ptr)
      A_CTRL_HI: rd_data = wreg[I_CTRL][15:8];
      A_CTRL_LO: rd_data = wreg[I_CTRL][7:0];
      A_FREQ_HI: rd_data = wreg[I_FREQ][15:8];
      A_FREQ_LO: rd_data = wreg[I_FREQ][7:0];
      A_RANGE:   rd_data = wreg[I_RANGE][7:0];
      A_ADDR:    rd_data = wreg[I_ADDR][7:0] | ADDR_FILL;
      A_FACT:    rd_data = {3'b000, FACTORY_RANGE};
      default:   rd_data = 8'h00;
    endcase
  end

  assign ctrl_word = wreg[I_CTRL];
  assign freq_code = wreg[I_FREQ][15:6];
  assign range_off = wreg[I_RANGE][4:0];
  assign dev_addr  = wreg[I_ADDR][2:0];
  assign wr_ctl    = wreg[I_ADDR][WC_BIT];
  assign busy      = (seq != S_IDLE);
endmodule

// File: rtl/twi_cfg_regs.sv
module twi_cfg_regs
  import twi_cfg_pkg::*;
#(
  parameter int          NV_BUSY_CYCLES = 2000,
  parameter int          SYNC_STAGES    = 2,
  parameter logic [15:0] DEF_CTRL       = 16'h0100,
  parameter logic [9:0]  DEF_FREQ       = 10'd500,
  parameter logic [4:0]  FACTORY_RANGE  = 5'h12,
  parameter logic [2:0]  DEF_DEV        = 3'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic [15:0] ctrl_word_o,
  output logic [9:0]  freq_code_o,
  output logic [4:0]  range_off_o,
  output logic [2:0]  addr_bits_o,
  output logic        wr_ctl_o,
  output logic        nv_busy_o
);
  logic       scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic       wr_v, wr_first, rd_req;
  logic [7:0] wr_byte, rd_data;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  twi_byte_engine i_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
    .dev_addr(addr_bits_o), .busy(nv_busy_o), .rd_data(rd_data),
    .sda_pull(sda_pull_o), .wr_v(wr_v), .wr_first(wr_first),
    .wr_byte(wr_byte), .rd_req(rd_req)
  );

  twi_reg_bank #(
    .NV_BUSY_CYCLES(NV_BUSY_CYCLES), .DEF_CTRL(DEF_CTRL), .DEF_FREQ(DEF_FREQ),
    .FACTORY_RANGE(FACTORY_RANGE), .DEF_DEV(DEF_DEV)
  ) i_bank (
    .clk(clk), .rst(rst), .stop_det(stop_det), .wr_v(wr_v),
    .wr_first(wr_first), .wr_byte(wr_byte), .rd_req(rd_req),
    .rd_data(rd_data), .ctrl_word(ctrl_word_o), .freq_code(freq_code_o),
    .range_off(range_off_o), .dev_addr(addr_bits_o), .wr_ctl(wr_ctl_o),
    .busy(nv_busy_o)
  );
endmodule

// File: rtl/twi_cfg_chk.sv
module twi_cfg_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_pull_o,
  input logic nv_busy_o
);
  // R10: reset leaves SDA released
  assert_rst_release_R10: assert property (@(posedge clk) rst |=> !sda_pull_o);

  // R10: reset starts a reload, so busy follows
  assert_rst_busy_R10: assert property (@(posedge clk) rst |=> nv_busy_o);

  // R13: pull-down moves only while SCL is low
  assert_sda_low_phase_R13: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_i);

  // R9: no ACK is driven while a save or reload runs
  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (rst)
    nv_busy_o |-> !sda_pull_o);
endmodule

bind twi_cfg_regs twi_cfg_chk i_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i),
  .sda_pull_o(sda_pull_o), .nv_busy_o(nv_busy_o)
);

// File: tb/test_twi_cfg_regs.sv
`timescale 1ns/1ps
module test_twi_cfg_regs;
  localparam int Q = 8;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic        sda_pull_o, wr_ctl_o, nv_busy_o;
  logic [15:0] ctrl_word_o;
  logic [9:0]  freq_code_o;
  logic [4:0]  range_off_o;
  logic [2:0]  addr_bits_o;
  wire         sda_line = sda_m & ~sda_pull_o;

  int checks = 0;
  int errors = 0;
  int r13_viol = 0;
  exp_t expq[$];
  logic [7:0] obs_val;
  event obs_ev;

  always #5 clk = ~clk;

  twi_cfg_regs i_twi_cfg_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .ctrl_word_o(ctrl_word_o),
    .freq_code_o(freq_code_o), .range_off_o(range_off_o),
    .addr_bits_o(addr_bits_o), .wr_ctl_o(wr_ctl_o), .nv_busy_o(nv_busy_o)
  );

  // R13 monitor: the slave must not move SDA while SCL is high
  always @(sda_pull_o) if (scl_m && !rst) r13_viol++;

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected item got %h expected none", obs_val);
      end else begin
        exp_t it;
        it = expq.pop_front();
        if (it.val !== obs_val) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, obs_val, it.val);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_t it;
    it.val = v;
    it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_val = v;
    -> obs_ev;
    #0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    observe({7'b0, ~s});
  endtask

  task automatic recv_byte(input logic last);
    logic s;
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    observe(b);
    clk_bit(last, s);
  endtask

  task automatic xfer_write(input logic [2:0] dev, input logic [7:0] ptr,
                            input logic [15:0] data, input int n,
                            input logic exp_ack, input string tag);
    bus_start();
    push({7'b0, exp_ack}, tag);
    send_byte({4'b1011, dev, 1'b0});
    if (exp_ack) begin
      push(8'h01, tag);
      send_byte(ptr);
      if (n == 2) begin
        push(8'h01, tag); send_byte(data[15:8]);
        push(8'h01, tag); send_byte(data[7:0]);
      end else if (n == 1) begin
        push(8'h01, tag); send_byte(data[7:0]);
      end
    end
    bus_stop();
  endtask

  task automatic xfer_read(input logic [2:0] dev, input logic [7:0] ptr,
                           input int n, input logic [15:0] exp, input string tag);
    bus_start();
    push(8'h01, tag); send_byte({4'b1011, dev, 1'b0});
    push(8'h01, tag); send_byte(ptr);
    bus_start();
    push(8'h01, tag); send_byte({4'b1011, dev, 1'b1});
    if (n == 2) begin
      push(exp[15:8], tag); recv_byte(1'b0);
      push(exp[7:0], tag);  recv_byte(1'b1);
    end else begin
      push(exp[7:0], tag);  recv_byte(1'b1);
    end
    bus_stop();
  endtask

  task automatic probe(input logic [2:0] dev, input logic exp_ack, input string tag);
    bus_start();
    push({7'b0, exp_ack}, tag);
    send_byte({4'b1011, dev, 1'b0});
    bus_stop();
  endtask

  task automatic wait_idle();
    while (nv_busy_o) tick(1);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(3);
    rst = 1'b0; tick(1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all R): got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R10 busy during reload", nv_busy_o, 1);
    wait_idle();
    chk("R10 sda released", sda_pull_o, 0);
    chk("R10 freq reloaded", freq_code_o, 500);
    chk("R10 range reloaded", range_off_o, 5'h12);
    chk("R10 ctrl reloaded", ctrl_word_o, 16'h0100);
    chk("R10 dev bits", addr_bits_o, 0);
    chk("R10 write-control", wr_ctl_o, 0);

    xfer_read(3'd0, 8'h02, 2, 16'h0100, "R3 ctrl two-byte read");
    chk("R4 sda released after read", sda_pull_o, 0);
    xfer_read(3'd0, 8'h08, 2, 16'h7D00, "R2 freq word");
    xfer_read(3'd0, 8'h0D, 1, 16'h00F0, "R12 address reg fill");
    xfer_read(3'd0, 8'h37, 1, 16'h0012, "R2 factory range");
    xfer_read(3'd0, 8'h0E, 1, 16'h0012, "R2 range offset");
    xfer_read(3'd0, 8'h20, 1, 16'h0000, "R2 unmapped");

    probe(3'd5, 1'b0, "R1 foreign address");

    xfer_write(3'd0, 8'h02, 16'hA5FF, 2, 1'b1, "R5 ctrl write");
    tick(Q);
    chk("R9 busy after save", nv_busy_o, 1);
    probe(3'd0, 1'b0, "R9 nack while busy");
    wait_idle();
    probe(3'd0, 1'b1, "R9 ack after busy");
    xfer_read(3'd0, 8'h02, 2, 16'hA5C0, "R12 ctrl low bits");
    chk("R5 ctrl output", ctrl_word_o, 16'hA5C0);

    do_reset(); wait_idle();
    chk("R5 ctrl survives reset", ctrl_word_o, 16'hA5C0);

    xfer_write(3'd0, 8'h0D, 16'h000D, 1, 1'b1, "R8 address write");
    tick(Q);
    chk("R8 busy on address save", nv_busy_o, 1);
    wait_idle();
    chk("R8 dev bits", addr_bits_o, 5);
    chk("R8 write-control set", wr_ctl_o, 1);
    probe(3'd0, 1'b0, "R1 old address");
    probe(3'd5, 1'b1, "R1 new address");

    xfer_write(3'd5, 8'h08, 16'h1234, 2, 1'b1, "R6 deferred write");
    tick(Q);
    chk("R6 no save started", nv_busy_o, 0);
    chk("R6 working freq", freq_code_o, 72);
    xfer_read(3'd5, 8'h08, 2, 16'h1200, "R6 working readback");

    do_reset(); wait_idle();
    chk("R6 freq restored", freq_code_o, 500);
    chk("R8 dev bits kept", addr_bits_o, 5);
    chk("R8 write-control kept", wr_ctl_o, 1);

    xfer_write(3'd5, 8'h08, 16'h4600, 2, 1'b1, "R7 staged write");
    xfer_write(3'd5, 8'h3F, 16'h0000, 0, 1'b1, "R7 commit command");
    tick(Q);
    chk("R7 busy on commit", nv_busy_o, 1);
    wait_idle();
    do_reset(); wait_idle();
    chk("R7 freq committed", freq_code_o, 280);

    xfer_write(3'd5, 8'h37, 16'h0005, 1, 1'b1, "R11 write read-only");
    xfer_read(3'd5, 8'h37, 1, 16'h0012, "R11 read-only unchanged");
    chk("R11 range unchanged", range_off_o, 5'h12);

    xfer_write(3'd5, 8'h0E, 16'h00FF, 1, 1'b1, "R12 range write");
    xfer_read(3'd5, 8'h0E, 1, 16'h001F, "R12 range upper bits");
    chk("R12 range output", range_off_o, 5'h1F);

    xfer_write(3'd5, 8'h0D, 16'h0005, 1, 1'b1, "R8 clear write-control");
    wait_idle();
    chk("R8 write-control cleared", wr_ctl_o, 0);

    tick(4);
    chk("R13 sda moved with scl high", r13_viol, 0);
    chk("R4 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule